// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block collects reset requests from every source on the chip and turns them into three kinds of active-low reset outputs. A hard system reset goes to the CPU and all peripherals and is raised only by the power-on and brown-out detectors. A second system reset, also chip-wide, is raised by those two detectors and by the external reset pin, the key-combination detector, the watchdog and the supply voltage monitor. A set of per-peripheral resets lets software restart a single peripheral without disturbing the rest of the chip.

Everything runs from the boot oscillator. The external pin is first synchronised, then filtered against glitches. Each system group has its own hold stage. The stage keeps its output low for a fixed number of boot-clock cycles after the last request, which gives supplies and oscillators time to settle. Power-on and brown-out force the system outputs low at once, with no clock edge needed. Every release is taken through a two-flop synchroniser. The key, watchdog, voltage-monitor and software requests are assumed to be synchronous to the boot clock already.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `por_req` or `bor_req` is high, `hard_rst_n`, `sys_rst_n` and every bit of `per_rst_n` are low. They go low as soon as the request rises, before any clock edge.
- R2: When the last of `por_req`/`bor_req` falls, `hard_rst_n` and `sys_rst_n` both return high together on the (HOLD_CYC+2)-th rising edge after the fall.
- R3: A high level on `key_req`, `wdt_req` or `svd_req` at a rising edge drives `sys_rst_n` low after that edge. `hard_rst_n` stays high.
- R4: After a synchronous system request, `sys_rst_n` returns high on the HOLD_CYC-th rising edge after the last edge at which the request was sampled high. A new request before release restarts that count.
- R5: A low level on `pin_rst_n` lasting 3 or fewer boot-clock cycles has no effect: `sys_rst_n` stays high. A low level lasting FILT_LEN (4) or more cycles is accepted.
- R6: A sustained low on `pin_rst_n` drives `sys_rst_n` low after the (FILT_LEN+3)-th edge. Once the pin returns high, `sys_rst_n` is released on the (HOLD_CYC+FILT_LEN+2)-th edge.
- R7: A one-cycle pulse on `sw_req[n]` drives `per_rst_n[n]` low for exactly SW_CYC (2) cycles after the edge that samples it. The other `per_rst_n` bits, `sys_rst_n` and `hard_rst_n` stay high.
- R8: Whenever `sys_rst_n` is low, all bits of `per_rst_n` are low.
- R9: Whenever `hard_rst_n` is low, `sys_rst_n` is also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_boot | input | 1 | Boot oscillator clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| por_req | input | 1 | Power-on detector request, active high, asynchronous |
| bor_req | input | 1 | Brown-out detector request, active high, asynchronous |
| key_req | input | 1 | Key-combination reset request, synchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous |
| svd_req | input | 1 | Supply voltage monitor reset request, synchronous |
| sw_req | input | NPERIPH | Per-peripheral software reset pulses |
| hard_rst_n | output | 1 | Hard system reset, active low |
| sys_rst_n | output | 1 | Second system reset, active low |
| per_rst_n | output | NPERIPH | Per-peripheral resets, active low |

## Verification
Some properties are checked on every cycle. These are: a sampled system request pulls its group low on the next edge, a released group stays released until a new request, and the pin filter only changes to the level the synchroniser presents. They also cover the nesting of the groups: hard implies second system, and second system implies all peripherals. Other behaviour can only be shown by the bench's scenarios. This includes the exact release cycle after power-on, after a watchdog pulse and after the pin, and the reload of the hold count by a second request. It also includes the 3-versus-4-cycle boundary of the glitch filter, the exact two-cycle width of a software reset, and the immediate drop with no clock edge on power-on and brown-out.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
// Package rstc_pkg
// Shared types and routing for the system reset controller.
// Assumes two system-level groups: index 0 is the hard group and index 1
// is the second system group.
package rstc_pkg;

    typedef enum logic [0:0] {
        GRP_HARD = 1'b0,
        GRP_SYS  = 1'b1
    } rst_grp_e;

    localparam int NUM_GRP = 2;

    // Synchronous (boot-clock domain) system-level request sources.
    typedef struct packed {
        logic pin;
        logic key;
        logic wdt;
        logic svd;
    } sync_src_t;

    // Route the synchronous sources to a group. The hard group takes no
    // synchronous source: only the detectors reach it, asynchronously.
    function automatic logic grp_sync_req(input int grp, input sync_src_t s);
        if (grp == int'(GRP_SYS)) begin
            return s.pin | s.key | s.wdt | s.svd;
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
`timescale 1ns/1ps
// Module rstc_pin_filter
// Synchronises the external active-low reset pin into the boot-clock
// domain with two flops. It then accepts a level change only after the
// synchronised level has differed from the filtered level for FILT_LEN
// consecutive cycles.
// Assumes srst_n_i is a synchronous active-low reset in the same domain.
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic srst_n_i,
    input  logic pin_n_i,
    output logic filt_n_o
);

    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk_i) begin
        if (!srst_n_i) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin_n_i};
        end
    end

    // Stability counter: flip the filtered level after FILT_LEN mismatches.
    always_ff @(posedge clk_i) begin
        if (!srst_n_i) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q[1] != filt_q) begin
            if (cnt_q == LAST) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt_n_o = filt_q;

    // R5
    filt_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!srst_n_i)
        !$stable(filt_q) |-> ($past(sync_q[1]) == filt_q));

    // R5
    filt_hold_on_match_chk: assert property (@(posedge clk_i) disable iff (!srst_n_i)
        (sync_q[1] == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/rstc_hold.sv
`timescale 1ns/1ps
// Module rstc_hold
// Reset hold stage for one system group. An asynchronous detector request
// drives the output low at once. The release passes through a two-flop
// synchroniser. Every cycle with a request reloads a hold counter, and the
// output is released HOLD_CYC edges after the last active edge.
// Assumes req_i is synchronous to clk_i.
module rstc_hold #(
    parameter int HOLD_CYC = 256
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic req_i,
    output logic rst_n_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

    logic [1:0]    rel_q;
    logic [CW-1:0] cnt_q;
    logic          rst_n_q;
    logic          active;

    // Release synchroniser: cleared at once by a detector, fills with ones.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            rel_q <= 2'b00;
        end else begin
            rel_q <= {rel_q[0], 1'b1};
        end
    end

    assign active = !rel_q[1] || req_i;

    // Hold counter: reloads while any request is active, else counts down.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cnt_q <= RELOAD;
        end else if (active) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Registered reset output, released when the last hold cycle expires.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            rst_n_q <= 1'b0;
        end else begin
            rst_n_q <= !(active || (cnt_q > CW'(1)));
        end
    end

    assign rst_n_o = rst_n_q;

    // R1
    detector_forces_low_chk: assert property (@(posedge clk_i)
        arst_i |-> !rst_n_o);

    // R3
    req_asserts_next_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        req_i |=> !rst_n_o);

    // R4
    released_stays_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (rst_n_o && !req_i) |=> rst_n_o);

endmodule

// File: rtl/rstc_soft.sv
`timescale 1ns/1ps
// Module rstc_soft
// Per-peripheral software reset generator. A one-cycle request pulse holds
// that peripheral's reset low for SW_CYC cycles. Any system-level reset
// (srst_n_i low) clears the counters and holds every output low.
// Assumes req_i is synchronous to clk_i.
module rstc_soft #(
    parameter int NPERIPH = 4,
    parameter int SW_CYC  = 2
) (
    input  logic               clk_i,
    input  logic               srst_n_i,
    input  logic [NPERIPH-1:0] req_i,
    output logic [NPERIPH-1:0] rst_n_o
);

    localparam int CW = $clog2(SW_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SW_CYC);

    for (genvar n = 0; n < NPERIPH; n++) begin : g_per
        logic [CW-1:0] cnt_q;

        // Pulse stretcher for peripheral n.
        always_ff @(posedge clk_i) begin
            if (!srst_n_i) begin
                cnt_q <= '0;
            end else if (req_i[n]) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign rst_n_o[n] = srst_n_i && (cnt_q == '0);

        // R7
        sw_req_asserts_chk: assert property (@(posedge clk_i) disable iff (!srst_n_i)
            req_i[n] |=> !rst_n_o[n]);
    end

endmodule

// File: rtl/sys_reset_ctrl.sv
`timescale 1ns/1ps
// Module sys_reset_ctrl
// Top of the system reset controller. It filters the external pin, routes
// every source to the system groups, instantiates one hold stage per
// group, and derives the per-peripheral resets from the second system
// group.
// Assumes key/wdt/svd/sw requests are synchronous to clk_boot, and that
// por_req is high at power-up.
module sys_reset_ctrl #(
    parameter int NPERIPH  = 4,
    parameter int FILT_LEN = 4,
    parameter int HOLD_CYC = 256,
    parameter int SW_CYC   = 2
) (
    input  logic               clk_boot,
    input  logic               pin_rst_n,
    input  logic               por_req,
    input  logic               bor_req,
    input  logic               key_req,
    input  logic               wdt_req,
    input  logic               svd_req,
    input  logic [NPERIPH-1:0] sw_req,
    output logic               hard_rst_n,
    output logic               sys_rst_n,
    output logic [NPERIPH-1:0] per_rst_n
);

    import rstc_pkg::*;

    logic                 det_req;
    logic                 pin_filt_n;
    sync_src_t            src;
    logic [NUM_GRP-1:0]   grp_req;
    logic [NUM_GRP-1:0]   grp_rst_n;

    assign det_req = por_req | bor_req;

    rstc_pin_filter #(
        .FILT_LEN (FILT_LEN)
    ) u_pin_filter (
        .clk_i    (clk_boot),
        .srst_n_i (hard_rst_n),
        .pin_n_i  (pin_rst_n),
        .filt_n_o (pin_filt_n)
    );

    // Gather the synchronous sources into one record.
    always_comb begin
        src.pin = !pin_filt_n;
        src.key = key_req;
        src.wdt = wdt_req;
        src.svd = svd_req;
    end

    // Decoder: map the sources onto each system group.
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_req[g] = grp_sync_req(g, src);
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        rstc_hold #(
            .HOLD_CYC (HOLD_CYC)
        ) u_hold (
            .clk_i   (clk_boot),
            .arst_i  (det_req),
            .req_i   (grp_req[g]),
            .rst_n_o (grp_rst_n[g])
        );
    end

    assign hard_rst_n = grp_rst_n[GRP_HARD];
    assign sys_rst_n  = grp_rst_n[GRP_SYS];

    rstc_soft #(
        .NPERIPH (NPERIPH),
        .SW_CYC  (SW_CYC)
    ) u_soft (
        .clk_i    (clk_boot),
        .srst_n_i (sys_rst_n),
        .req_i    (sw_req),
        .rst_n_o  (per_rst_n)
    );

    // R9
    hard_implies_sys_chk: assert property (@(posedge clk_boot) disable iff (det_req)
        !hard_rst_n |-> !sys_rst_n);

    // R8
    sys_implies_per_chk: assert property (@(posedge clk_boot) disable iff (det_req)
        !sys_rst_n |-> (per_rst_n == '0));

endmodule

// File: tb/sys_reset_ctrl_tb.sv
`timescale 1ns/1ps
module sys_reset_ctrl_tb;

    localparam int NP   = 4;
    localparam int FLEN = 4;
    localparam int HOLD = 256;
    localparam int SWC  = 2;

    logic          clk = 1'b0;
    logic          pin_rst_n = 1'b1;
    logic          por_req = 1'b0;
    logic          bor_req = 1'b0;
    logic          key_req = 1'b0;
    logic          wdt_req = 1'b0;
    logic          svd_req = 1'b0;
    logic [NP-1:0] sw_req = '0;
    logic          hard_rst_n;
    logic          sys_rst_n;
    logic [NP-1:0] per_rst_n;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sys_reset_ctrl #(
        .NPERIPH (NP), .FILT_LEN (FLEN), .HOLD_CYC (HOLD), .SW_CYC (SWC)
    ) u_dut (
        .clk_boot (clk), .pin_rst_n (pin_rst_n), .por_req (por_req),
        .bor_req (bor_req), .key_req (key_req), .wdt_req (wdt_req),
        .svd_req (svd_req), .sw_req (sw_req), .hard_rst_n (hard_rst_n),
        .sys_rst_n (sys_rst_n), .per_rst_n (per_rst_n)
    );

    // Expected cycle counts derived from the requirements.
    function automatic int exp_sync_release();  return HOLD;            endfunction
    function automatic int exp_det_release();   return HOLD + 2;        endfunction
    function automatic int exp_pin_assert();    return FLEN + 3;        endfunction
    function automatic int exp_pin_release();   return HOLD + FLEN + 2; endfunction
    function automatic logic [NP-1:0] exp_per_one_low(input int idx);
        return ~(NP'(1) << idx);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_sys_release(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!sys_rst_n && n < 2000);
    endtask

    task automatic sync_pulse(input int src, input int len);
        for (int i = 0; i < len; i++) begin
            case (src)
                0: key_req = 1'b1;
                1: wdt_req = 1'b1;
                default: svd_req = 1'b1;
            endcase
            tick();
            // R3: low after the first sampling edge, hard group untouched
            if (i == 0) begin
                check(!sys_rst_n, "R3 sys low", int'(sys_rst_n), 0);
                check(hard_rst_n, "R3 hard high", int'(hard_rst_n), 1);
                check(per_rst_n == '0, "R8 per low", int'(per_rst_n), 0);
            end
        end
        key_req = 1'b0; wdt_req = 1'b0; svd_req = 1'b0;
    endtask

    task automatic sw_pulse(input int idx);
        sw_req = NP'(1) << idx;
        tick();
        sw_req = '0;
        check(per_rst_n == exp_per_one_low(idx), "R7 first cycle", int'(per_rst_n),
              int'(exp_per_one_low(idx)));
        check(sys_rst_n && hard_rst_n, "R7 system untouched", int'({hard_rst_n, sys_rst_n}), 3);
        tick();
        check(per_rst_n == exp_per_one_low(idx), "R7 second cycle", int'(per_rst_n),
              int'(exp_per_one_low(idx)));
        tick();
        check(per_rst_n == '1, "R7 released", int'(per_rst_n), (1 << NP) - 1);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int hn;
        int sn;
        bit seen;
        void'($urandom(32'd4242));

        // R1: power-on drops everything with no clock edge
        #1 por_req = 1'b1;
        #1;
        check(!hard_rst_n && !sys_rst_n && per_rst_n == '0, "R1 por async",
              int'({hard_rst_n, sys_rst_n}), 0);
        tick(); tick(); tick();
        por_req = 1'b0;

        // R2: both system groups release together
        hn = 0; sn = 0;
        for (int i = 1; i < 1000 && (hn == 0 || sn == 0); i++) begin
            tick();
            if (hard_rst_n && hn == 0) hn = i;
            if (sys_rst_n && sn == 0) sn = i;
        end
        check(hn == exp_det_release(), "R2 hard release", hn, exp_det_release());
        check(sn == exp_det_release(), "R2 sys release", sn, exp_det_release());
        check(per_rst_n == '1, "R8 per follow release", int'(per_rst_n), (1 << NP) - 1);

        // R3/R4: watchdog pulse, exact release
        sync_pulse(1, 1);
        wait_sys_release(n);
        check(n == exp_sync_release(), "R4 wdt release", n, exp_sync_release());

        // R4: second key request reloads the hold count
        sync_pulse(0, 1);
        for (int i = 0; i < 100; i++) tick();
        sync_pulse(0, 2);
        wait_sys_release(n);
        check(n == exp_sync_release(), "R4 reload", n, exp_sync_release());

        // R5: a 3-cycle glitch on the pin is ignored
        pin_rst_n = 1'b0;
        tick(); tick(); tick();
        pin_rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (!sys_rst_n) seen = 1;
        end
        check(!seen, "R5 glitch ignored", int'(seen), 0);

        // R6: sustained pin low, assertion and release timing
        pin_rst_n = 1'b0;
        n = 0;
        do begin tick(); n++; end while (sys_rst_n && n < 50);
        check(n == exp_pin_assert(), "R6 pin assert", n, exp_pin_assert());
        check(hard_rst_n, "R6 hard untouched", int'(hard_rst_n), 1);
        for (int i = 0; i < 10; i++) tick();
        pin_rst_n = 1'b1;
        wait_sys_release(n);
        check(n == exp_pin_release(), "R6 pin release", n, exp_pin_release());

        // R5: a 4-cycle pin low is accepted
        pin_rst_n = 1'b0;
        tick(); tick(); tick(); tick();
        pin_rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (!sys_rst_n) seen = 1;
        end
        check(seen, "R5 four-cycle accepted", int'(seen), 1);
        wait_sys_release(n);

        // R7: software reset on each peripheral
        for (int p = 0; p < NP; p++) sw_pulse(p);

        // R9/R1: brown-out acts like power-on
        bor_req = 1'b1;
        #1;
        check(!hard_rst_n && !sys_rst_n, "R9 bor async", int'({hard_rst_n, sys_rst_n}), 0);
        tick(); tick();
        bor_req = 1'b0;
        wait_sys_release(n);
        check(n == exp_det_release(), "R2 bor release", n, exp_det_release());
        check(hard_rst_n, "R2 bor hard release", int'(hard_rst_n), 1);

        // Random mix of synchronous sources and software resets
        for (int it = 0; it < 16; it++) begin
            int src;
            src = int'($urandom % 4);
            if (src < 3) begin
                sync_pulse(src, 1 + int'($urandom % 3));
                wait_sys_release(n);
                check(n == exp_sync_release(), "R4 random release", n, exp_sync_release());
            end else begin
                sw_pulse(int'($urandom % NP));
            end
            for (int i = 0; i < int'($urandom % 5); i++) tick();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule